// File: doc/BRIEF.md
# Serial Port Status Flags and Clock Source Selection

This block holds the status flags of a serial port that runs in either asynchronous or synchronous mode, together with a two-bit clock field. The field picks the serial clock source and decides what the external clock pin does. A CPU reads and writes both registers over a simple synchronous bus. Read data arrives one cycle after the request. Writes carry 16 bits and have no byte enables. The transmit and receive logic around the block raise flags through a hardware status vector.

Six of the flags can be cleared by the CPU, but only by the usual read-then-write handshake. The CPU must first see the flag as 1 in a status read. A later write of 0 to that bit then clears it. Writing a 1 never sets a flag. Two further flags, the framing-error and parity-error flags, mirror hardware levels and cannot be changed by the CPU.

The clock field is decoded into three outputs: external source selected, pin driven as a clock output, and pin released as a general port. The decode depends on the current mode.

Top module: `serstat_regs`

## Requirements
- R1: After reset the status flags read 0x0060: bit 6 (transmit end) and bit 5 (transmit buffer empty) are 1 and all other bits are 0. The clock field is 00 and the read data is 0.
- R2: A read with `bus_sel`=1 and `bus_wr`=0 presents data on `bus_rdata` one cycle later. With `bus_addr`=0 the data is the status register, whose bits 15..8 are 0. With `bus_addr`=1 the data is the clock field in bits 1..0, and bits 15..2 are 0.
- R3: A 1 on a clearable position of `hw_stat` sets that flag in the next cycle. The clearable positions are bits 7, 6, 5, 4, 1 and 0. This set wins over a CPU clear of the same bit in the same cycle.
- R4: A status write never changes a clearable flag from 0 to 1, whatever the written data.
- R5: A status write of 0 to a clearable flag that has not been read as 1 since the last status write leaves the flag unchanged.
- R6: A status read that returns 1 in a clearable bit arms that bit. The next status write clears every armed bit written as 0. That write disarms all bits, whatever its data.
- R7: Flag bits 3 (framing error) and 2 (parity error) take the levels of `hw_stat[3]` and `hw_stat[2]` one cycle later. CPU writes have no effect on them, and they are never armed.
- R8: In asynchronous mode (`sync_mode`=0), the clock field decodes as follows. Field 00 gives internal clock with the pin released as a port. Field 01 gives internal clock with the pin driven as a clock output. Field 1x gives an external clock, with the pin as an input.
- R9: In synchronous mode (`sync_mode`=1), field 0x gives internal clock with the pin driven as a clock output. Field 1x gives an external clock, with the pin as an input. The pin is never released as a port in this mode.
- R10: A write with `bus_addr`=1 loads the clock field from `bus_wdata[1:0]` in the next cycle. It leaves the flags and the armed bits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Bus access request |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 1 | 0 = status register, 1 = clock field |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, one cycle after the request |
| hw_stat | input | 8 | Set pulses on clearable bits; levels on bits 3 and 2 |
| sync_mode | input | 1 | 1 = synchronous mode, 0 = asynchronous |
| flags | output | 8 | Current status flags |
| clk_ext_sel | output | 1 | External clock source selected |
| clk_pin_out_en | output | 1 | Clock pin driven as a clock output |
| clk_pin_is_port | output | 1 | Clock pin released as a general port |

## Verification
On every cycle, the checker confirms four things: a hardware set always lands, a write never raises a clear flag, the two error flags follow their inputs, and the zero upper read byte holds. It also checks that the three clock outputs are consistent with each other. Whether a clear takes effect depends on the read history since the last write. That history is only visible in bench sequences: read-then-clear, clear-without-read, and a write that disarms and is followed by a stale clear. The full clock-field decode table for both modes is also covered by directed bench cases.

// File: rtl/serstat_pkg.sv
package serstat_pkg;
    localparam int FLAG_W  = 8;
    localparam int REG_W   = 16;
    localparam int CK_W    = 2;
    localparam logic [FLAG_W-1:0] CLR_MASK = 8'hF3;
    localparam logic [FLAG_W-1:0] RO_MASK  = 8'h0C;
    localparam logic [FLAG_W-1:0] RST_VAL  = 8'h60;

    typedef struct packed {
        logic [FLAG_W-1:0] flags;
        logic [FLAG_W-1:0] armed;
    } flag_state_t;
endpackage

// File: rtl/serstat_flags.sv
module serstat_flags
    import serstat_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_hit,
    input  logic              wr_hit,
    input  logic [FLAG_W-1:0] wdata,
    input  logic [FLAG_W-1:0] hw_stat,
    output logic [FLAG_W-1:0] flags
);
    flag_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < FLAG_W; i++) begin
            if (CLR_MASK[i]) begin
                // clear only an armed bit written as 0; a set event wins
                st_d.flags[i] = (st_q.flags[i] & ~(wr_hit & ~wdata[i] & st_q.armed[i]))
                              | hw_stat[i];
            end else begin
                st_d.flags[i] = hw_stat[i] & RO_MASK[i];
            end
        end
        if (wr_hit)
            st_d.armed = '0;
        else if (rd_hit)
            st_d.armed = st_q.armed | (st_q.flags & CLR_MASK);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.flags <= RST_VAL;
            st_q.armed <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flags = st_q.flags;
endmodule

// File: rtl/serstat_clkdec.sv
module serstat_clkdec
    import serstat_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_hit,
    input  logic [CK_W-1:0] wdata,
    input  logic            sync_mode,
    output logic [CK_W-1:0] ck_field,
    output logic            clk_ext_sel,
    output logic            clk_pin_out_en,
    output logic            clk_pin_is_port
);
    logic [CK_W-1:0] ck_d, ck_q;

    always_comb begin
        ck_d = ck_q;
        if (wr_hit)
            ck_d = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ck_q <= '0;
        else        ck_q <= ck_d;
    end

    // high bit selects the external source; low bit matters only for internal
    always_comb begin
        clk_ext_sel     = ck_q[1];
        clk_pin_out_en  = !ck_q[1] && (sync_mode || ck_q[0]);
        clk_pin_is_port = !ck_q[1] && !sync_mode && !ck_q[0];
    end

    assign ck_field = ck_q;
endmodule

// File: rtl/serstat_regs.sv
module serstat_regs
    import serstat_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic              bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    input  logic [FLAG_W-1:0] hw_stat,
    input  logic              sync_mode,
    output logic [FLAG_W-1:0] flags,
    output logic              clk_ext_sel,
    output logic              clk_pin_out_en,
    output logic              clk_pin_is_port
);
    localparam logic STAT_ADDR = 1'b0;
    localparam logic CK_ADDR   = 1'b1;

    logic            stat_rd, stat_wr, ck_wr, any_rd;
    logic [CK_W-1:0] ck_field;
    logic [REG_W-1:0] rdata_d, rdata_q;
    logic            unused_wdata;

    assign any_rd  = bus_sel && !bus_wr;
    assign stat_rd = any_rd && (bus_addr == STAT_ADDR);
    assign stat_wr = bus_sel && bus_wr && (bus_addr == STAT_ADDR);
    assign ck_wr   = bus_sel && bus_wr && (bus_addr == CK_ADDR);
    assign unused_wdata = ^bus_wdata[REG_W-1:FLAG_W];

    serstat_flags u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_hit  (stat_rd),
        .wr_hit  (stat_wr),
        .wdata   (bus_wdata[FLAG_W-1:0]),
        .hw_stat (hw_stat),
        .flags   (flags)
    );

    serstat_clkdec u_clkdec (
        .clk             (clk),
        .rst_n           (rst_n),
        .wr_hit          (ck_wr),
        .wdata           (bus_wdata[CK_W-1:0]),
        .sync_mode       (sync_mode),
        .ck_field        (ck_field),
        .clk_ext_sel     (clk_ext_sel),
        .clk_pin_out_en  (clk_pin_out_en),
        .clk_pin_is_port (clk_pin_is_port)
    );

    always_comb begin
        rdata_d = rdata_q;
        if (any_rd) begin
            if (bus_addr == STAT_ADDR)
                rdata_d = {{(REG_W-FLAG_W){1'b0}}, flags};
            else
                rdata_d = {{(REG_W-CK_W){1'b0}}, ck_field};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rdata_q <= '0;
        else        rdata_q <= rdata_d;
    end

    assign bus_rdata = rdata_q;
endmodule

// File: rtl/serstat_regs_chk.sv
module serstat_regs_chk
    import serstat_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [REG_W-1:0]  bus_rdata,
    input logic [FLAG_W-1:0] hw_stat,
    input logic              sync_mode,
    input logic [FLAG_W-1:0] flags,
    input logic              clk_ext_sel,
    input logic              clk_pin_out_en,
    input logic              clk_pin_is_port
);
    assert_hw_set_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && ($past(hw_stat & CLR_MASK) != '0)) |->
        ((flags & $past(hw_stat & CLR_MASK)) == $past(hw_stat & CLR_MASK)));

    assert_write_never_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && ($past(hw_stat & CLR_MASK) == '0)) |->
        ((flags & ~$past(flags) & CLR_MASK) == '0));

    assert_err_flags_follow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((flags & RO_MASK) == ($past(hw_stat) & RO_MASK)));

    assert_upper_byte_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[REG_W-1:FLAG_W] == '0);

    assert_ext_not_driven_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clk_ext_sel |-> !clk_pin_out_en && !clk_pin_is_port);

    assert_port_only_async_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clk_pin_is_port |-> !sync_mode && !clk_pin_out_en);
endmodule

bind serstat_regs serstat_regs_chk u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .bus_rdata       (bus_rdata),
    .hw_stat         (hw_stat),
    .sync_mode       (sync_mode),
    .flags           (flags),
    .clk_ext_sel     (clk_ext_sel),
    .clk_pin_out_en  (clk_pin_out_en),
    .clk_pin_is_port (clk_pin_is_port)
);

// File: tb/serstat_regs_bench.sv
`timescale 1ns/1ps
module serstat_regs_bench;
    localparam logic [7:0] CLR = 8'hF3;
    localparam logic [7:0] RO  = 8'h0C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0, bus_addr = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [7:0]  hw_stat = '0;
    logic        sync_mode = 1'b0;
    logic [7:0]  flags;
    logic        clk_ext_sel, clk_pin_out_en, clk_pin_is_port;

    int n_chk = 0;
    int n_fail = 0;

    logic [7:0] m_flags, m_armed;
    logic [1:0] m_ck;

    always #4 clk = ~clk;

    serstat_regs u_serstat_regs (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .hw_stat(hw_stat), .sync_mode(sync_mode), .flags(flags),
        .clk_ext_sel(clk_ext_sel), .clk_pin_out_en(clk_pin_out_en),
        .clk_pin_is_port(clk_pin_is_port)
    );

    function automatic logic [2:0] exp_dec(input logic [1:0] ck, input logic sm);
        // {ext, out_en, is_port}
        if (ck[1])       return 3'b100;
        else if (sm)     return 3'b010;
        else if (ck[0])  return 3'b010;
        else             return 3'b001;
    endfunction

    function automatic logic [7:0] next_flags(input logic [7:0] f, input logic [7:0] a,
            input logic wr0, input logic [7:0] wd, input logic [7:0] hs);
        logic [7:0] clr;
        clr = (wr0 ? (~wd & a) : 8'h00) & CLR;
        return (((f & ~clr) | hs) & CLR) | (hs & RO);
    endfunction

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic chk_dec(input string tag);
        chk(tag, {13'd0, clk_ext_sel, clk_pin_out_en, clk_pin_is_port},
            {13'd0, exp_dec(m_ck, sync_mode)});
    endtask

    task automatic step(input logic sel, input logic wr, input logic addr,
                        input logic [15:0] wd, input logic [7:0] hs);
        logic rd0, wr0, rd1, wr1;
        logic [15:0] exp_rd;
        bus_sel = sel; bus_wr = wr; bus_addr = addr; bus_wdata = wd; hw_stat = hs;
        rd0 = sel && !wr && !addr; rd1 = sel && !wr && addr;
        wr0 = sel && wr && !addr;  wr1 = sel && wr && addr;
        exp_rd = rd0 ? {8'h00, m_flags} : {14'd0, m_ck};
        @(posedge clk);
        #2;
        m_flags = next_flags(m_flags, m_armed, wr0, wd[7:0], hs);
        if (wr0)      m_armed = 8'h00;
        else if (rd0) m_armed = m_armed | (m_flags_prev_mask());
        if (wr1)      m_ck = wd[1:0];
        chk("flags R3 R4 R5 R6 R7", {8'h00, flags}, {8'h00, m_flags});
        if (rd0 || rd1) chk("read data R2", bus_rdata, exp_rd);
        chk_dec("clock decode R8 R9 R10");
        @(negedge clk);
        bus_sel = 1'b0; hw_stat = hw_stat & RO;
    endtask

    // armed bits use the flags seen by the read, captured before the edge
    logic [7:0] seen_flags;
    function automatic logic [7:0] m_flags_prev_mask();
        return seen_flags & CLR;
    endfunction
    always @(posedge clk) seen_flags <= flags;

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        m_flags = 8'h60; m_armed = 8'h00; m_ck = 2'b00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("reset flags R1", {8'h00, flags}, 16'h0060);
        chk("reset rdata R1", bus_rdata, 16'h0000);
        chk("reset clock field R1", {13'd0, clk_ext_sel, clk_pin_out_en, clk_pin_is_port}, 16'h0001);

        // R5 write 0 without a prior read does not clear
        step(1, 1, 0, 16'h0000, 8'h00);
        chk("no clear without read R5", {8'h00, flags}, 16'h0060);

        // R6 read then write 0 clears; R2 read value and upper byte
        step(1, 0, 0, 16'h0000, 8'h00);
        chk("status read R2", bus_rdata, 16'h0060);
        step(1, 1, 0, 16'hFF00, 8'h00);
        chk("read then clear R6", {8'h00, flags}, 16'h0000);

        // R4 writing ones never sets
        step(1, 1, 0, 16'hFFFF, 8'h00);
        chk("write one no set R4", {8'h00, flags}, 16'h0000);

        // R3 set wins against a same-cycle clear of an armed bit
        step(0, 0, 0, 16'h0000, 8'h80);
        step(1, 0, 0, 16'h0000, 8'h00);
        step(1, 1, 0, 16'h0000, 8'h80);
        chk("set beats clear R3", {8'h00, flags}, 16'h0080);

        // R6 write disarms: write ones, then a zero write finds nothing armed
        step(0, 0, 0, 16'h0000, 8'h01);
        step(1, 0, 0, 16'h0000, 8'h00);
        step(1, 1, 0, 16'h00FF, 8'h00);
        step(1, 1, 0, 16'h0000, 8'h00);
        chk("stale clear after disarm R6", {8'h00, flags & 8'h01}, 16'h0001);

        // R7 error flags follow levels, writes ignored
        step(0, 0, 0, 16'h0000, 8'h08);
        chk("framing flag level R7", {8'h00, flags & RO}, 16'h0008);
        step(1, 0, 0, 16'h0000, 8'h0C);
        step(1, 1, 0, 16'h0000, 8'h0C);
        chk("error flags ignore write R7", {8'h00, flags & RO}, 16'h000C);
        step(0, 0, 0, 16'h0000, 8'h00);
        chk("error flags drop R7", {8'h00, flags & RO}, 16'h0000);

        // R8 R9 R10 full decode table and read-back
        for (int sm = 0; sm < 2; sm++) begin
            for (int ck = 0; ck < 4; ck++) begin
                sync_mode = sm[0];
                step(1, 1, 1, {14'd0, ck[1:0]}, 8'h00);
                chk(sm ? "sync decode R9" : "async decode R8",
                    {13'd0, clk_ext_sel, clk_pin_out_en, clk_pin_is_port},
                    {13'd0, exp_dec(ck[1:0], sm[0])});
                step(1, 0, 1, 16'h0000, 8'h00);
                chk("clock field read back R10", bus_rdata, {14'd0, ck[1:0]});
            end
        end

        // constrained random traffic
        for (int i = 0; i < 3000; i++) begin
            logic [7:0] hs;
            hs = 8'h00;
            if ($urandom_range(0, 3) == 0) hs = 8'($urandom) & CLR & 8'($urandom);
            hs = hs | (8'($urandom) & RO);
            sync_mode = ($urandom_range(0, 15) == 0) ? ~sync_mode : sync_mode;
            step($urandom_range(0, 3) != 0, $urandom_range(0, 1) == 1,
                 $urandom_range(0, 4) == 0, 16'($urandom), hs);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule